// File: doc/BRIEF.md
# Split Up/Down Counter Integrator with MSB Quantizer

This block is the digital loop filter of an oscillator-driven phase-domain sigma-delta modulator. A 7-bit up/down counter is clocked by a current-controlled oscillator. Its counting direction follows an external square-wave phase signal, so the count is the integral of oscillator frequency multiplied by that signal. Once per sampling period, the counter's most significant bit is carried into the sampling clock domain and becomes the modulator's 1-bit output.

The counter has two sections. The low two bits run as a Gray-code counter at the full oscillator rate. The upper five bits form a binary counter that moves only when the fine section wraps, so it runs at one quarter of the fine rate. This split is what lets the counter keep up with oscillator clocks of several hundred MHz.

The direction input is asynchronous to the oscillator, so one flop re-times it before it reaches the counter. A trim mode forces up-counting. In that mode the counter acts as a divide-by-128, and a slow square wave is produced that can be measured off-chip.

Top module: `ctr_integrator`

## Requirements
- R1: When `osc_rst_n` is released, `integ_state` reads 64 (mid-code: coarse 10000, fine Gray 00), `trim_div` reads 0 and the internal direction flop holds "up". When `smp_rst_n` is released, `msb_bit` reads 0.
- R2: `integ_state` changes by exactly +1 or -1, modulo 128, on every rising edge of `osc_clk`. Wrap-around 127→0 and 0→127 is allowed.
- R3: `up_dn` (1 = up, 0 = down) passes through one `osc_clk` flop before it steers the counter. A level driven before edge k therefore first sets the step direction at edge k+1.
- R4: The fine section follows the Gray sequence 00→01→11→10→00 when counting up, and the reverse when counting down. It maps to binary 0,1,2,3. The coarse section steps only on the fine 10→00 transition (up) or the fine 00→10 transition (down).
- R5: `msb_bit` equals bit 6 of the count. It passes through two `smp_clk` synchronizer flops and one output flop, so it follows a steady MSB within three `smp_clk` rising edges.
- R6: While `trim_en` is 1, the counter steps +1 on every edge and `up_dn` has no effect on `integ_state`.
- R7: `trim_div` toggles exactly on the edges where the count steps from 127 to 0 while `trim_en` is 1. A 127→0 step in normal mode leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock that drives the counter |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator domain |
| up_dn | input | 1 | Asynchronous phase square wave: 1 counts up, 0 counts down |
| trim_en | input | 1 | Trim mode: count up only, divide-by-128 |
| integ_state | output | 7 | Binary integrator count |
| trim_div | output | 1 | Divided-clock output; toggles every 128 counts in trim mode |
| smp_clk | input | 1 | Sampling clock of the modulator |
| smp_rst_n | input | 1 | Active-low asynchronous reset, sampling domain |
| msb_bit | output | 1 | 1-bit quantizer output |

## Verification
If the fine Gray section takes a wrong step, or the coarse section misses or duplicates a carry, `integ_state` is off by 4 or by an odd amount at the very next oscillator edge. The error then persists, so the stepped vector table catches it at its next checkpoint. If the direction re-timing has the wrong depth, every direction reversal moves the count by 2 at the next checkpoint. A wrong synchronizer depth or a wrong choice of MSB bit shows on `msb_bit` within a few sampling periods while the count dithers around a fixed level. A divider fault shows on `trim_div` at the first 127→0 step in trim mode.

// File: rtl/cint_pkg.sv
package cint_pkg;
    localparam int CNT_W  = 7;
    localparam int FINE_W = 2;
    localparam int CRS_W  = CNT_W - FINE_W;

    function automatic logic [FINE_W-1:0] gray_to_bin(input logic [FINE_W-1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    function automatic logic [FINE_W-1:0] gray_step(input logic [FINE_W-1:0] g, input logic up);
        logic [FINE_W-1:0] n;
        unique case (g)
            2'b00:   n = up ? 2'b01 : 2'b10;
            2'b01:   n = up ? 2'b11 : 2'b00;
            2'b11:   n = up ? 2'b10 : 2'b01;
            default: n = up ? 2'b00 : 2'b11;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/cint_dir_resync.sv
module cint_dir_resync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed { logic dir; } rs_t;
    rs_t r_d, r_q;

    always_comb begin
        r_d.dir = async_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{dir: RST_VAL};
        else        r_q <= r_d;
    end

    assign sync_out = r_q.dir;
endmodule

// File: rtl/cint_fine_gray.sv
module cint_fine_gray
    import cint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up,
    output logic [FINE_W-1:0] gray,
    output logic              wrap_up,
    output logic              wrap_dn
);
    typedef struct packed { logic [FINE_W-1:0] g; } fg_t;
    fg_t f_d, f_q;

    always_comb begin
        f_d.g = gray_step(f_q.g, up);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign gray    = f_q.g;
    assign wrap_up = up  && (f_q.g == 2'b10);
    assign wrap_dn = !up && (f_q.g == 2'b00);

    // R4: exactly one Gray bit flips per oscillator edge
    a_r4_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(f_q.g ^ $past(f_q.g)) == 1);
endmodule

// File: rtl/cint_coarse.sv
module cint_coarse
    import cint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [CRS_W-1:0] value
);
    localparam logic [CRS_W-1:0] MID = CRS_W'(1) << (CRS_W - 1);

    typedef struct packed { logic [CRS_W-1:0] c; } cr_t;
    cr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (step_up)      c_d.c = c_q.c + CRS_W'(1);
        else if (step_dn) c_d.c = c_q.c - CRS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{c: MID};
        else        c_q <= c_d;
    end

    assign value = c_q.c;
endmodule

// File: rtl/cint_msb_sampler.sv
module cint_msb_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic msb_in,
    output logic q_bit
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              out;
    } sm_t;
    sm_t s_d, s_q;

    always_comb begin
        s_d.sync = {s_q.sync[STAGES-2:0], msb_in};
        s_d.out  = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_bit = s_q.out;

    // R5: the output bit only moves to the value the last synchronizer stage held
    a_r5_bit_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (s_q.out != $past(s_q.out))) |-> (s_q.out == $past(s_q.sync[STAGES-1])));
endmodule

// File: rtl/ctr_integrator.sv
module ctr_integrator
    import cint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             osc_rst_n,
    input  logic             up_dn,
    input  logic             trim_en,
    output logic [CNT_W-1:0] integ_state,
    output logic             trim_div,
    input  logic             smp_clk,
    input  logic             smp_rst_n,
    output logic             msb_bit
);
    logic              dir_q;
    logic              up_eff;
    logic [FINE_W-1:0] fine;
    logic [CRS_W-1:0]  coarse;
    logic              wrap_up, wrap_dn;

    cint_dir_resync #(.RST_VAL(1'b1)) dir_i (
        .clk(osc_clk), .rst_n(osc_rst_n), .async_in(up_dn), .sync_out(dir_q));

    assign up_eff = trim_en | dir_q;

    cint_fine_gray fine_i (
        .clk(osc_clk), .rst_n(osc_rst_n), .up(up_eff),
        .gray(fine), .wrap_up(wrap_up), .wrap_dn(wrap_dn));

    cint_coarse coarse_i (
        .clk(osc_clk), .rst_n(osc_rst_n), .step_up(wrap_up), .step_dn(wrap_dn),
        .value(coarse));

    assign integ_state = {coarse, gray_to_bin(fine)};

    typedef struct packed { logic div; } td_t;
    td_t t_d, t_q;

    always_comb begin
        t_d.div = t_q.div ^ (trim_en && (integ_state == '1));
    end

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) t_q <= '0;
        else            t_q <= t_d;
    end

    assign trim_div = t_q.div;

    cint_msb_sampler #(.STAGES(SYNC_STAGES)) smp_i (
        .clk(smp_clk), .rst_n(smp_rst_n), .msb_in(integ_state[CNT_W-1]), .q_bit(msb_bit));

    // R4: coarse section moves only on a fine wrap in the matching direction
    a_r4_coarse_on_wrap: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        ($past(osc_rst_n) && (coarse != $past(coarse))) |->
        ((fine == 2'b00 && $past(fine) == 2'b10) || (fine == 2'b10 && $past(fine) == 2'b00)));

    // R3: step direction comes from the flop, one edge late
    a_r3_dir_late: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        ($past(osc_rst_n) && !$past(trim_en)) |->
        (integ_state == ($past(dir_q) ? $past(integ_state) + CNT_W'(1)
                                      : $past(integ_state) - CNT_W'(1))));

    // R6: trim mode always counts up
    a_r6_trim_up: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        ($past(osc_rst_n) && $past(trim_en)) |-> (integ_state == $past(integ_state) + CNT_W'(1)));

    // R7: divider toggles only on a 127->0 step in trim mode
    a_r7_div_on_wrap: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        $past(osc_rst_n) |->
        ((trim_div != $past(trim_div)) == ($past(trim_en) && ($past(integ_state) == '1))));
endmodule

// File: tb/ctr_integrator_tb_top.sv
module ctr_integrator_tb_top;
    logic       osc_clk = 1'b0;
    logic       smp_clk = 1'b0;
    logic       osc_rst_n = 1'b0;
    logic       smp_rst_n = 1'b0;
    logic       up_dn = 1'b1;
    logic       trim_en = 1'b0;
    logic [6:0] integ_state;
    logic       trim_div;
    logic       msb_bit;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #2.5 osc_clk = ~osc_clk;      // 200 MHz
    initial begin
        #1;
        forever #20 smp_clk = ~smp_clk;
    end

    ctr_integrator dut_i (
        .osc_clk(osc_clk), .osc_rst_n(osc_rst_n), .up_dn(up_dn), .trim_en(trim_en),
        .integ_state(integ_state), .trim_div(trim_div),
        .smp_clk(smp_clk), .smp_rst_n(smp_rst_n), .msb_bit(msb_bit));

    // fields: {direction, edge count, expected integ_state}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 8'd10, 7'd74},
        {1'b0, 8'd20, 7'd56},
        {1'b0, 8'd60, 7'd124},
        {1'b1, 8'd7,  7'd1},
        {1'b1, 8'd3,  7'd4},
        {1'b0, 8'd5,  7'd1},
        {1'b1, 8'd2,  7'd1},
        {1'b0, 8'd1,  7'd2},
        {1'b0, 8'd2,  7'd0},
        {1'b1, 8'd1,  7'd127},
        {1'b1, 8'd64, 7'd63},
        {1'b0, 8'd1,  7'd64}
    };

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge osc_clk);
        @(negedge osc_clk);
    endtask

    task automatic dither(input int n);
        for (int k = 0; k < n; k++) begin
            up_dn = k[0];
            @(negedge osc_clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge osc_clk);
        @(negedge osc_clk);
        osc_rst_n = 1'b1;
        smp_rst_n = 1'b1;
        // R1: reset state
        check("R1 count", integ_state, 64);
        check("R1 trim_div", trim_div, 0);
        check("R1 msb_bit", msb_bit, 0);

        // R2/R3/R4: stepped table with direction reversals and wraps
        for (int i = 0; i < NV; i++) begin
            up_dn = VEC[i][15];
            run(int'(VEC[i][14:7]));
            check($sformatf("R2/R3/R4 vec %0d", i), integ_state, int'(VEC[i][6:0]));
        end
        // R7: normal-mode 127->0 steps left divider untouched
        check("R7 no toggle in normal mode", trim_div, 0);

        // R6/R7: trim mode, up_dn held low to show it is ignored
        trim_en = 1'b1;
        up_dn   = 1'b0;
        run(63);
        check("R6 trim count", integ_state, 127);
        check("R7 div before wrap", trim_div, 0);
        run(1);
        check("R6 trim wrap", integ_state, 0);
        check("R7 div toggled", trim_div, 1);
        run(127);
        check("R6 trim count 2", integ_state, 127);
        check("R7 div held", trim_div, 1);
        run(1);
        check("R7 div toggled back", trim_div, 0);

        // R3: leaving trim, direction flop still holds down for one edge
        trim_en = 1'b0;
        up_dn   = 1'b1;
        run(33);
        check("R3 after trim", integ_state, 31);

        // R5: dither around a low level, then a high level
        dither(40);
        check("R5 msb low", msb_bit, 0);
        up_dn = 1'b1;
        run(40);
        dither(40);
        check("R5 msb high", msb_bit, 1);
        check("R5 msb matches count", msb_bit, int'(integ_state[6]));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        done = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge osc_clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule